// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Atomic Bit Operations

This block is a general-purpose I/O port of up to 32 pins, controlled over a simple single-cycle register bus. The bus offers a byte address, a write strobe, write data and combinational read data. The port holds an output latch and a direction register. Three write-only registers change selected latch bits in one bus write, so software never needs a read-modify-write sequence: one sets bits, one clears them and one inverts them.

Pin inputs pass through a two-flop synchronizer and can be read back from a read-only register. For each pin, the port drives a value and an output enable.

A parameter mask marks which pins exist. Bits of absent pins read as zero and cannot be written.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads zero, and both `pin_oe` and `pin_out` are all zero.
- R2: Offset 0x00 is the output latch. A write replaces it, and a read returns it.
- R3: A write to offset 0x04 sets every latch bit whose write-data bit is 1. All other bits keep their value.
- R4: A write to offset 0x08 clears every latch bit whose write-data bit is 1. All other bits keep their value.
- R5: A write to offset 0x0C inverts every latch bit whose write-data bit is 1. All other bits keep their value.
- R6: A read of offset 0x04, 0x08 or 0x0C returns zero.
- R7: Offset 0x14 is the direction register and can be read and written. A bit value of 1 makes the pin an output. `pin_oe` equals the direction register. `pin_out` carries the latch bit only where the direction bit is 1, and is 0 elsewhere.
- R8: Offset 0x10 returns the pin inputs, delayed by two clock edges through the synchronizer. A write to offset 0x10 has no effect.
- R9: Bits outside the `IMPL_MASK` parameter read as zero in every register, never take written values, and never drive `pin_oe` or `pin_out`.
- R10: Writes to any other offset are ignored, including unaligned offsets. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | PINS | Asynchronous pin levels |
| pin_out | output | PINS | Pin drive values |
| pin_oe | output | PINS | Per-pin output enables |

## Verification
A wrong bit in the output latch or in the direction register shows on `pin_out` or `pin_oe` one edge after the write that caused it. A read of the matching offset shows the same bit with no delay. A synchronizer with the wrong depth shifts the moment a pin change appears at offset 0x10 away from the second edge, so the bench samples at both the first and the second edge. A mask or decode fault makes a bit or offset that should read as zero read as nonzero.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int          PINS      = 32,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] IMPL_MASK = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  localparam logic [PINS-1:0] MASK = IMPL_MASK[PINS-1:0];

  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_SET  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_TGL  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_IN   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_DIR  = ADDR_W'(8'h14);

  logic [PINS-1:0] out_q, dir_q, sync1_q, sync2_q;
  logic [PINS-1:0] wbits;

  assign wbits = bus_wdata[PINS-1:0] & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_DATA: out_q <= wbits;
        OFS_SET:  out_q <= out_q | wbits;
        OFS_CLR:  out_q <= out_q & ~wbits;
        OFS_TGL:  out_q <= out_q ^ wbits;
        OFS_DIR:  dir_q <= wbits;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in & MASK;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DATA: bus_rdata[PINS-1:0] = out_q;
      OFS_IN:   bus_rdata[PINS-1:0] = sync2_q;
      OFS_DIR:  bus_rdata[PINS-1:0] = dir_q;
      default: ;
    endcase
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q & dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int          PINS      = 32,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] IMPL_MASK = 32'hFFFF_FFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [PINS-1:0]   pin_in,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe
);
  localparam logic [PINS-1:0] MASK = IMPL_MASK[PINS-1:0];
  logic [1:0] live_cnt;
  logic       mapped;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;

  assign mapped = bus_addr inside {ADDR_W'(8'h00), ADDR_W'(8'h04), ADDR_W'(8'h08),
                                   ADDR_W'(8'h0C), ADDR_W'(8'h10), ADDR_W'(8'h14)};

  assert_reset_oe_R1: assert property (@(posedge clk) $rose(rst_n) |-> pin_oe == '0 && pin_out == '0);
  assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(8'h04) |=>
      ((pin_out & $past(bus_wdata[PINS-1:0]) & pin_oe & MASK) == ($past(bus_wdata[PINS-1:0]) & pin_oe & MASK)));
  assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(8'h08) |=> (pin_out & $past(bus_wdata[PINS-1:0])) == '0);
  assert_wo_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr inside {ADDR_W'(8'h04), ADDR_W'(8'h08), ADDR_W'(8'h0C)} |-> bus_rdata == '0);
  assert_dir_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(8'h14) |=> pin_oe == ($past(bus_wdata[PINS-1:0]) & MASK));
  assert_out_gated_R7: assert property (@(posedge clk) disable iff (!rst_n) (pin_out & ~pin_oe) == '0);
  assert_sync_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    live_cnt >= 2'd2 && bus_addr == ADDR_W'(8'h10) |-> bus_rdata[PINS-1:0] == ($past(pin_in, 2) & MASK));
  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~MASK) == '0 && (bus_rdata[PINS-1:0] & ~MASK) == '0);
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n) !mapped |-> bus_rdata == '0);
endmodule

bind gpio_port gpio_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h7FFF_FFF0;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic [31:0] exp_out = '0, exp_dir = '0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.PINS(32), .ADDR_W(8), .IMPL_MASK(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic check_state(string req);
    logic [31:0] v;
    rd(8'h00, v); check(req, v, exp_out);
    rd(8'h14, v); check(req, v, exp_dir);
    check(req, pin_oe, exp_dir);
    check(req, pin_out, exp_out & exp_dir);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    foreach (v[i]) ;
    for (int a = 0; a < 8'h18; a += 4) begin rd(8'(a), v); check("R1", v, 0); end
    check("R1", pin_oe, 0); check("R1", pin_out, 0);
  endtask

  task automatic t_data;
    wr(8'h14, 32'hFFFF_FFFF); exp_dir = MASK;
    wr(8'h00, 32'hA5A5_5A5A); exp_out = 32'hA5A5_5A5A & MASK;
    check_state("R2");
    wr(8'h00, 32'h0F0F_F0F0); exp_out = 32'h0F0F_F0F0 & MASK;
    check_state("R2");
  endtask

  task automatic t_set_clr_tgl;
    logic [31:0] v;
    wr(8'h04, 32'h1234_0300); exp_out |= 32'h1234_0300 & MASK; check_state("R3");
    wr(8'h04, 32'h0);                                          check_state("R3");
    wr(8'h08, 32'h0F00_00F0); exp_out &= ~(32'h0F00_00F0 & MASK); check_state("R4");
    wr(8'h0C, 32'hFFFF_0000); exp_out ^= 32'hFFFF_0000 & MASK; check_state("R5");
    wr(8'h0C, 32'h0000_00FF); exp_out ^= 32'h0000_00FF & MASK; check_state("R5");
    rd(8'h04, v); check("R6", v, 0);
    rd(8'h08, v); check("R6", v, 0);
    rd(8'h0C, v); check("R6", v, 0);
  endtask

  task automatic t_dir;
    wr(8'h14, 32'h0000_FFF0); exp_dir = 32'h0000_FFF0 & MASK; check_state("R7");
    wr(8'h00, 32'hFFFF_FFFF); exp_out = MASK;                check_state("R7");
    wr(8'h14, 32'h0);         exp_dir = 0;                   check_state("R7");
  endtask

  task automatic t_input;
    logic [31:0] v;
    @(negedge clk); pin_in = 32'hDEAD_BEEF; bus_addr = 8'h10;
    @(negedge clk); rd(8'h10, v); check("R8 one edge", v, 0);
    @(negedge clk); rd(8'h10, v); check("R8 two edges", v, 32'hDEAD_BEEF & MASK);
    wr(8'h10, 32'h0);
    rd(8'h10, v); check("R8 write ignored", v, 32'hDEAD_BEEF & MASK);
    check_state("R8");
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(8'h14, 32'hFFFF_FFFF); exp_dir = MASK;
    wr(8'h00, 32'hFFFF_FFFF); exp_out = MASK;
    rd(8'h00, v); check("R9", v & ~MASK, 0);
    check("R9", pin_oe & ~MASK, 0);
    wr(8'h08, 32'hFFFF_FFFF); exp_out = 0;
    wr(8'h0C, 32'h8000_000F); check_state("R9");
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(8'h00, 32'h0000_1230); exp_out = 32'h0000_1230;
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h15, 32'h0);
    check_state("R10");
    rd(8'h18, v); check("R10", v, 0);
    rd(8'h01, v); check("R10", v, 0);
    rd(8'hFC, v); check("R10", v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_data();
    t_set_clr_tgl();
    t_dir();
    t_input();
    t_mask();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule